// File: doc/BRIEF.md
# Scale-3 Spline Wavelet Filter

This block takes a stream of electrocardiogram samples, one 12-bit two's-complement value per clock, and returns one 14-bit two's-complement coefficient per clock. Each coefficient is the third-scale output of an undecimated quadratic-spline wavelet transform. The output works as a smoothed first derivative of the input. A rising edge gives positive values and a falling edge gives negative values. A symmetric peak therefore becomes a positive extremum followed by a negative extremum, and the zero crossing between them marks the peak's position. A downstream peak and zero-crossing detector uses this output to locate beats.

The datapath has three stages. The first two are smoothing stages with weights (1,3,3,1)/8. The third is a difference stage with weights 2·(1,−1). There is no down-sampling. Instead, the tap spacing doubles from one stage to the next (1, 2, then 4 samples), so the output keeps one-sample time resolution. The symmetric taps are added in pairs before weighting. The factor of three is built from a shift and an add, and the division by eight is an arithmetic right shift. Every delay line clears on reset. A valid strobe stays low until every tap that feeds a coefficient holds a real sample.

Top module: `wvl_scale3_filter`

## Requirements
- R1: While reset is asserted, `coef_o` is 0 and `coef_valid_o` is 0.
- R2: Samples are numbered from 0, starting with the sample captured at the first rising edge after reset is released. `coef_valid_o` is 0 for the coefficients of samples 0 to 12. It is 1 from the coefficient of sample 13 onward, and it stays 1 until the next reset.
- R3: Each smoothing stage computes floor((a[n] + 3·a[n−s] + 3·a[n−2s] + a[n−3s]) / 8). The tap spacing s is 1 in the first stage and 2 in the second. Taps that reach back before sample 0 read as 0.
- R4: The output is z[n] = 2·(b[n] − b[n−4]), where b is the output of the second smoothing stage. Every valid coefficient is therefore even.
- R5: The output never wraps. For any 12-bit input, every valid coefficient equals the exact value from R3 and R4 and lies within ±8190. A full-scale step from −2048 to +2047 gives only non-negative coefficients.
- R6: One coefficient is produced per clock. The coefficient for sample n appears on `coef_o` after the second rising edge following the edge that captured sample n.
- R7: Take a symmetric triangular pulse whose apex is at sample a. Its positive extremum comes before its negative extremum. z[a+6] is greater than 0, z[a+7] is less than 0, and z[a+7+k] = −z[a+6−k] for every k where both coefficients are valid.
- R8: The divisions by eight round toward minus infinity, including for small negative intermediate sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample is taken on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all delay lines |
| smp_i | input | 12 | Input sample, two's complement |
| coef_o | output | 14 | Scale-3 wavelet coefficient, two's complement |
| coef_valid_o | output | 1 | High when `coef_o` depends only on real samples |

## Verification
- **Impulse:** a single impulse gives the impulse response directly. It separates the tap spacings and weights of the three stages, and it fixes the exact output latency.
- **Full-scale step:** a step from −2048 to +2047 pushes the difference stage to its largest swing, so any loss of width or wrap of the sign shows up.
- **Small negative run:** a short run of −1 values followed by zeros gives sums that are not multiples of eight. This separates rounding toward minus infinity from rounding toward zero.
- **Pseudo-random sweep and triangle:** a sweep across the whole input range checks the general arithmetic. A symmetric triangular pulse checks the shape of the output pair: the order of the extrema, the zero crossing half a sample after apex + 6, and the exact antisymmetry around it.

// File: rtl/wvl_scale3_pkg.sv
package wvl_scale3_pkg;

    // Smoothing stage: weights 1,3,3,1 with a right shift of three
    localparam int LP_SPAN  = 3;   // number of spacings covered by one smoothing stage
    localparam int LP_SHIFT = 3;   // divide by eight

    // Samples needed before the output depends only on real data:
    // each smoothing stage reaches back LP_SPAN*spacing, the difference stage one spacing.
    function automatic int fill_depth(input int num_lp);
        return LP_SPAN * ((1 << num_lp) - 1) + (1 << num_lp);
    endfunction

endpackage

// File: rtl/wvl_lowpass_stage.sv
module wvl_lowpass_stage #(
    parameter int W       = 12,
    parameter int SPACING = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    import wvl_scale3_pkg::*;

    localparam int DEPTH = LP_SPAN * SPACING;
    localparam int ACW   = W + 3;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] dly;   // dly[k-1] holds the input from k samples ago
        logic [W-1:0]            y;
    } lp_state_t;

    lp_state_t st_d, st_q;

    logic signed [ACW-1:0] outer_sum;
    logic signed [ACW-1:0] inner_sum;
    logic signed [ACW-1:0] acc;

    always_comb begin
        st_d = st_q;
        // symmetric pre-addition: end taps share weight 1, middle taps weight 3
        outer_sum = ACW'(din) + ACW'($signed(st_q.dly[DEPTH-1]));
        inner_sum = ACW'($signed(st_q.dly[SPACING-1])) +
                    ACW'($signed(st_q.dly[2*SPACING-1]));
        acc       = outer_sum + (inner_sum <<< 1) + inner_sum;
        st_d.y    = W'(acc >>> LP_SHIFT);
        st_d.dly[0] = din;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.dly[i] = st_q.dly[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = $signed(st_q.y);

endmodule

// File: rtl/wvl_highpass_stage.sv
module wvl_highpass_stage #(
    parameter int W       = 12,
    parameter int OUT_W   = 14,
    parameter int SPACING = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [W-1:0]     din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int RW = W + 2;

    typedef struct packed {
        logic [SPACING-1:0][W-1:0] dly;
        logic [OUT_W-1:0]          y;
    } hp_state_t;

    hp_state_t st_d, st_q;

    logic signed [RW-1:0] diff;
    logic signed [RW-1:0] res;

    always_comb begin
        st_d   = st_q;
        diff   = RW'(din) - RW'($signed(st_q.dly[SPACING-1]));
        res    = diff <<< 1;
        st_d.y = OUT_W'(res);   // truncation to the output word
        st_d.dly[0] = din;
        for (int i = 1; i < SPACING; i++) begin
            st_d.dly[i] = st_q.dly[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = $signed(st_q.y);

endmodule

// File: rtl/wvl_fill_tracker.sv
module wvl_fill_tracker #(
    parameter int FILL = 13,
    parameter int LAT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);
    localparam int CW = $clog2(FILL + 1);

    typedef struct packed {
        logic [CW-1:0]  cnt;
        logic [LAT-1:0] vpipe;
    } fill_state_t;

    fill_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != CW'(FILL)) st_d.cnt = st_q.cnt + 1'b1;
        st_d.vpipe[0] = (st_q.cnt == CW'(FILL));
        for (int i = 1; i < LAT; i++) begin
            st_d.vpipe[i] = st_q.vpipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = st_q.vpipe[LAT-1];

endmodule

// File: rtl/wvl_scale3_filter.sv
module wvl_scale3_filter #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 14,
    parameter int NUM_LP = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  smp_i,
    output logic signed [OUT_W-1:0] coef_o,
    output logic                    coef_valid_o
);
    localparam int HP_SPACING = 1 << NUM_LP;
    localparam int FILL       = wvl_scale3_pkg::fill_depth(NUM_LP);
    localparam int LAT        = NUM_LP + 1;

    logic signed [IN_W-1:0] lp_chain [NUM_LP+1];

    assign lp_chain[0] = smp_i;

    generate
        for (genvar g = 0; g < NUM_LP; g++) begin : g_lp
            wvl_lowpass_stage #(
                .W      (IN_W),
                .SPACING(1 << g)
            ) i_lp (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (lp_chain[g]),
                .dout (lp_chain[g+1])
            );
        end
    endgenerate

    wvl_highpass_stage #(
        .W      (IN_W),
        .OUT_W  (OUT_W),
        .SPACING(HP_SPACING)
    ) i_hp (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (lp_chain[NUM_LP]),
        .dout (coef_o)
    );

    wvl_fill_tracker #(
        .FILL(FILL),
        .LAT (LAT)
    ) i_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .ready_o(coef_valid_o)
    );

endmodule

// File: rtl/wvl_scale3_checker.sv
module wvl_scale3_checker #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 14,
    parameter int NUM_LP = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [OUT_W-1:0] coef_o,
    input logic                    coef_valid_o
);
    localparam int LIMIT = wvl_scale3_pkg::fill_depth(NUM_LP) + NUM_LP + 1;
    localparam int CW    = $clog2(LIMIT + 1);
    localparam int MAXC  = 2 * ((1 << IN_W) - 1);

    logic [CW-1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cyc_q <= '0;
        else if (cyc_q != CW'(LIMIT))  cyc_q <= cyc_q + 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (coef_o == '0 && !coef_valid_o));

    assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid_o |=> coef_valid_o);

    assert_valid_onset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coef_valid_o) |-> (cyc_q == CW'(LIMIT)));

    assert_even_coef_R4: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid_o |-> !coef_o[0]);

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid_o |-> (int'(coef_o) <= MAXC && int'(coef_o) >= -MAXC));

endmodule

bind wvl_scale3_filter wvl_scale3_checker #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .NUM_LP(NUM_LP)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .coef_o      (coef_o),
    .coef_valid_o(coef_valid_o)
);

// File: tb/test_wvl_scale3_filter.sv
`timescale 1ns/1ps
module test_wvl_scale3_filter;

    localparam int N = 64;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [11:0] smp = '0;
    logic signed [13:0] coef;
    logic               coef_valid;

    logic signed [11:0] stim [N];
    int                 zout [N];
    int                 errors = 0;
    int                 checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    wvl_scale3_filter i_wvl_scale3_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_i       (smp),
        .coef_o      (coef),
        .coef_valid_o(coef_valid)
    );

    // ---------------- behavioural model ----------------
    function automatic int xs(int n);
        if (n < 0 || n >= N) return 0;
        return int'(stim[n]);
    endfunction

    function automatic int y1m(int n);
        if (n < 0) return 0;
        return (xs(n) + 3*xs(n-1) + 3*xs(n-2) + xs(n-3)) >>> 3;
    endfunction

    function automatic int y2m(int n);
        if (n < 0) return 0;
        return (y1m(n) + 3*y1m(n-2) + 3*y1m(n-4) + y1m(n-6)) >>> 3;
    endfunction

    function automatic int zm(int n);
        if (n < 0) return 0;
        return 2 * (y2m(n) - y2m(n-4));
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp   = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    // Drive stim[] and compare every cycle against the model.
    task automatic run_stream(input string tag);
        do_reset();
        rst_n = 1'b1;
        for (int m = 0; m < N; m++) begin
            smp = stim[m];
            @(posedge clk);
            @(negedge clk);
            if (m >= 2) begin
                int idx = m - 2;   // R6: two edges after the capturing edge
                check($sformatf("R2 valid idx=%0d", idx), int'(coef_valid), (idx >= 13) ? 1 : 0);
                zout[idx] = int'(coef);
                if (idx >= 13)
                    check($sformatf("%s idx=%0d", tag, idx), int'(coef), zm(idx));
            end
        end
    endtask

    task automatic clear_stim();
        for (int i = 0; i < N; i++) stim[i] = '0;
    endtask

    task automatic t_reset();
        smp = 12'sd1000;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 coef in reset", int'(coef), 0);
        check("R1 valid in reset", int'(coef_valid), 0);
    endtask

    task automatic t_impulse();
        clear_stim();
        stim[15] = 12'sd512;
        run_stream("R3 R6 impulse");
        check("R6 before impulse", zout[14], 0);
        check("R6 impulse onset", zout[15], 16);
    endtask

    task automatic t_step();
        clear_stim();
        for (int i = 0; i < N; i++) stim[i] = (i < 30) ? -12'sd2048 : 12'sd2047;
        run_stream("R5 step");
        for (int i = 13; i < 62; i++) begin
            if (zout[i] < 0) check($sformatf("R5 sign idx=%0d", i), zout[i], 0);
        end
        checks++;
    endtask

    task automatic t_sweep();
        for (int i = 0; i < N; i++) stim[i] = 12'(((i * 1103 + 77) % 4096) - 2048);
        run_stream("R4 sweep");
        for (int i = 13; i < 62; i++) check($sformatf("R4 even idx=%0d", i), zout[i] & 1, 0);
    endtask

    task automatic t_negative();
        clear_stim();
        for (int i = 0; i < 30; i++) stim[i] = (i % 3 == 0) ? -12'sd1 : 12'sd0;
        run_stream("R8 floor");
    endtask

    task automatic t_triangle();
        int a = 20;
        int imax = 13;
        int imin = 13;
        clear_stim();
        for (int k = -10; k <= 10; k++) stim[a+k] = 12'(1500 - 150 * (k < 0 ? -k : k));
        run_stream("R3 triangle");
        for (int i = 13; i < 62; i++) begin
            if (zout[i] > zout[imax]) imax = i;
            if (zout[i] < zout[imin]) imin = i;
        end
        check("R7 max before min", (imax < imin) ? 1 : 0, 1);
        check("R7 positive before apex+7", (zout[a+6] > 0) ? 1 : 0, 1);
        check("R7 negative at apex+7", (zout[a+7] < 0) ? 1 : 0, 1);
        for (int k = 0; k <= 13; k++)
            check($sformatf("R7 antisym k=%0d", k), zout[a+7+k], -zout[a+6-k]);
    endtask

    initial begin
        #(4ns * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_impulse();
        t_step();
        t_sweep();
        t_negative();
        t_triangle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule